// File: doc/BRIEF.md
# Last-Translation Micro-Cache

This block sits in front of a fully associative TLB and short-circuits repeated translations of the same page pair. It holds four independent slots: one for each pairing of access kind (read or write) with page parity (even or odd). Each slot keeps a valid bit, the page-pair tag and the physical frame number of the last translation that succeeded for that kind and parity.

A request presents a virtual address and an access kind. If the matching slot is valid and its tag agrees, the physical address is returned in the same cycle. Otherwise a lookup request is raised, and the full TLB walk runs outside this block. When the walk succeeds, its result is written back through a fill port. A strobe that flushes every slot is given whenever any TLB entry is rewritten.

Top module: `xlat_shortcut`

## Requirements
- R1: After reset all four slots are invalid, so no request hits until a fill has been accepted.
- R2: The tag of an address is its bits from bit 13 upward. Bit 12 is the page parity. The slot used is index {access kind, parity}, with write = 1 and odd = 1: read-even is 0, read-odd is 1, write-even is 2 and write-odd is 3.
- R3: `hit` is high in the same cycle as `req_valid` exactly when the selected slot is valid and its tag equals the request tag.
- R4: On a hit, `hit_pa` is the stored frame number placed above the 12 untouched offset bits of `req_va`. When there is no hit, `hit_pa` is zero.
- R5: `lookup_req` is high exactly when `req_valid` is high and `hit` is low.
- R6: An accepted fill writes `fill_page[19:1]` as the tag and `fill_pfn` as the frame into slot {fill_wr, fill_page[0]}, and sets that slot valid. The result is visible to requests from the next cycle.
- R7: A read fill is accepted only when `fill_v` is 1. A write fill is accepted only when both `fill_v` and `fill_d` are 1. A refused fill leaves every slot unchanged.
- R8: A cycle with `inval` high clears all four slots from the next cycle on.
- R9: When `inval` and `fill_valid` are high in the same cycle, the invalidate wins and no slot is valid afterwards.
- R10: Filling one slot leaves the valid bit, tag and frame of the other three slots unchanged, so a stale tag in a sibling slot never turns valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_wr | input | 1 | Request is a write (1) or a read (0) |
| req_va | input | 32 | Virtual address of the request |
| hit | output | 1 | Request served from a slot |
| hit_pa | output | 32 | Physical address on a hit, zero otherwise |
| lookup_req | output | 1 | Request missed; a full TLB walk is needed |
| fill_valid | input | 1 | Fill strobe from a completed TLB walk |
| fill_wr | input | 1 | Fill belongs to the write side |
| fill_page | input | 20 | Virtual page number of the fill (tag and parity) |
| fill_pfn | input | 20 | Physical frame number of the fill |
| fill_v | input | 1 | Matched page is valid |
| fill_d | input | 1 | Matched page is writable |
| inval | input | 1 | Flush all slots (TLB entry written) |

## Verification
On every cycle, the bound checker confirms the following:
- a hit and a lookup request are never raised together;
- a hit always carries the request's page offset;
- no hit appears in the cycle after a flush, even when a fill arrived with that flush;
- an accepted fill is answered by a hit when the next cycle asks for the same page and kind.

Only the bench scenarios can show the rest: that refused write fills (D clear) or read fills (V clear) leave a slot empty, that the four slots stay independent across every kind and parity pairing, and that the correct frame comes back after a run of mixed fills and flushes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int unsigned NUM_SLOTS = 4;
   typedef logic [1:0] slot_idx_t;

   // slot numbering: access kind is the upper bit, page parity the lower
   function automatic slot_idx_t slot_of(input logic is_wr, input logic odd);
      return {is_wr, odd};
   endfunction
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot #(
   parameter int unsigned TAG_W = 19,
   parameter int unsigned PFN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [TAG_W-1:0] tag_in,
   input  logic [PFN_W-1:0] pfn_in,
   output logic             vld,
   output logic [TAG_W-1:0] tag,
   output logic [PFN_W-1:0] pfn
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         tag <= '0;
         pfn <= '0;
      end else if (clr) begin
         vld <= 1'b0;            // flush has priority over a fill
      end else if (load) begin
         vld <= 1'b1;
         tag <= tag_in;
         pfn <= pfn_in;
      end
   end
endmodule

// File: rtl/xlat_select.sv
module xlat_select #(
   parameter int unsigned NSLOT = 4,
   parameter int unsigned TAG_W = 19,
   parameter int unsigned PFN_W = 20,
   localparam int unsigned SEL_W = $clog2(NSLOT)
) (
   input  logic [SEL_W-1:0]            sel,
   input  logic [NSLOT-1:0]            vld,
   input  logic [NSLOT-1:0][TAG_W-1:0] tags,
   input  logic [NSLOT-1:0][PFN_W-1:0] pfns,
   input  logic [TAG_W-1:0]            tag_in,
   output logic                        hit_raw,
   output logic [PFN_W-1:0]            pfn_out
);
   always_comb begin
      hit_raw = vld[sel] && (tags[sel] == tag_in);
      pfn_out = pfns[sel];
   end
endmodule

// File: rtl/xlat_shortcut.sv
module xlat_shortcut
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned PA_W   = 32,
   parameter int unsigned OFFS_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_wr,
   input  logic [VA_W-1:0]        req_va,
   output logic                   hit,
   output logic [PA_W-1:0]        hit_pa,
   output logic                   lookup_req,
   input  logic                   fill_valid,
   input  logic                   fill_wr,
   input  logic [VA_W-OFFS_W-1:0] fill_page,
   input  logic [PA_W-OFFS_W-1:0] fill_pfn,
   input  logic                   fill_v,
   input  logic                   fill_d,
   input  logic                   inval
);
   localparam int unsigned PAGE_W = VA_W - OFFS_W;
   localparam int unsigned TAG_W  = PAGE_W - 1;
   localparam int unsigned PFN_W  = PA_W - OFFS_W;

   if (OFFS_W < 1 || VA_W <= OFFS_W + 1 || PA_W <= OFFS_W) begin : g_bad_cfg
      $error("xlat_shortcut: address widths must leave a tag above the parity bit");
   end

   logic [NUM_SLOTS-1:0]            vld;
   logic [NUM_SLOTS-1:0][TAG_W-1:0] tags;
   logic [NUM_SLOTS-1:0][PFN_W-1:0] pfns;
   logic [NUM_SLOTS-1:0]            ld;
   logic                            fill_ok;
   slot_idx_t                       fill_sel;
   slot_idx_t                       req_sel;
   logic                            hit_raw;
   logic [PFN_W-1:0]                pfn_sel;

   // write side caches only pages that are both valid and writable
   assign fill_ok  = fill_valid && fill_v && (!fill_wr || fill_d);
   assign fill_sel = slot_of(fill_wr, fill_page[0]);
   assign req_sel  = slot_of(req_wr, req_va[OFFS_W]);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign ld[i] = fill_ok && (fill_sel == slot_idx_t'(i));
      xlat_slot #(.TAG_W(TAG_W), .PFN_W(PFN_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (inval),
         .load   (ld[i]),
         .tag_in (fill_page[PAGE_W-1:1]),
         .pfn_in (fill_pfn),
         .vld    (vld[i]),
         .tag    (tags[i]),
         .pfn    (pfns[i])
      );
   end

   xlat_select #(.NSLOT(NUM_SLOTS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_select (
      .sel     (req_sel),
      .vld     (vld),
      .tags    (tags),
      .pfns    (pfns),
      .tag_in  (req_va[VA_W-1:OFFS_W+1]),
      .hit_raw (hit_raw),
      .pfn_out (pfn_sel)
   );

   assign hit        = req_valid && hit_raw;
   assign lookup_req = req_valid && !hit_raw;
   assign hit_pa     = hit ? {pfn_sel, req_va[OFFS_W-1:0]} : '0;
endmodule

// File: rtl/xlat_shortcut_chk.sv
module xlat_shortcut_chk #(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned PA_W   = 32,
   parameter int unsigned OFFS_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_wr,
   input logic [VA_W-1:0]        req_va,
   input logic                   hit,
   input logic [PA_W-1:0]        hit_pa,
   input logic                   lookup_req,
   input logic                   fill_valid,
   input logic                   fill_wr,
   input logic [VA_W-OFFS_W-1:0] fill_page,
   input logic                   fill_v,
   input logic                   fill_d,
   input logic                   inval
);
   assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit);

   assert_hit_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> req_valid);

   assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_pa[OFFS_W-1:0] == req_va[OFFS_W-1:0]));

   assert_hit_miss_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && lookup_req));

   assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !inval && fill_v && (!fill_wr || fill_d)) |=>
      (!(req_valid && (req_wr == $past(fill_wr)) &&
         (req_va[VA_W-1:OFFS_W] == $past(fill_page))) || hit));

   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> !hit);

   assert_flush_beats_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inval && fill_valid) |=> !hit);
endmodule

bind xlat_shortcut xlat_shortcut_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_wr     (req_wr),
   .req_va     (req_va),
   .hit        (hit),
   .hit_pa     (hit_pa),
   .lookup_req (lookup_req),
   .fill_valid (fill_valid),
   .fill_wr    (fill_wr),
   .fill_page  (fill_page),
   .fill_v     (fill_v),
   .fill_d     (fill_d),
   .inval      (inval)
);

// File: tb/xlat_shortcut_tb.sv
module xlat_shortcut_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_wr;
   logic [31:0] req_va;
   logic        hit, lookup_req;
   logic [31:0] hit_pa;
   logic        fill_valid, fill_wr, fill_v, fill_d, inval;
   logic [19:0] fill_page, fill_pfn;

   int checks = 0;
   int errors = 0;

   // reference state, derived from the requirements
   logic        mv [4];
   logic [18:0] mt [4];
   logic [19:0] mp [4];
   logic [31:0] lcg = 32'h1357_9bdf;

   always #5 clk = ~clk;

   xlat_shortcut u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr), .req_va(req_va),
      .hit(hit), .hit_pa(hit_pa), .lookup_req(lookup_req), .fill_valid(fill_valid),
      .fill_wr(fill_wr), .fill_page(fill_page), .fill_pfn(fill_pfn), .fill_v(fill_v),
      .fill_d(fill_d), .inval(inval)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R2 R3 R4 R5: drive a request, compare against the reference model
   task automatic probe(input string tag, input logic wr, input logic [31:0] va);
      logic [1:0]  idx;
      logic        eh;
      logic [31:0] epa;
      @(negedge clk);
      req_valid = 1'b1; req_wr = wr; req_va = va;
      #1;
      idx = {wr, va[12]};
      eh  = mv[idx] && (mt[idx] == va[31:13]);
      epa = eh ? {mp[idx], va[11:0]} : 32'h0;
      chk({tag, " hit R3"}, {31'h0, hit}, {31'h0, eh});
      chk({tag, " pa R4"}, hit_pa, epa);
      chk({tag, " lookup R5"}, {31'h0, lookup_req}, {31'h0, !eh});
      req_valid = 1'b0;
   endtask

   // fill and/or flush for one cycle, then update the reference (R6 R7 R8 R9)
   task automatic fill(input logic fv, input logic wr, input logic [19:0] page,
                       input logic [19:0] pfn, input logic v, input logic d, input logic inv);
      logic [1:0] idx;
      @(negedge clk);
      fill_valid = fv; fill_wr = wr; fill_page = page; fill_pfn = pfn;
      fill_v = v; fill_d = d; inval = inv;
      @(posedge clk);
      #1;
      fill_valid = 1'b0; inval = 1'b0;
      idx = {wr, page[0]};
      if (inv) begin
         for (int k = 0; k < 4; k++) mv[k] = 1'b0;
      end else if (fv && v && (!wr || d)) begin
         mv[idx] = 1'b1; mt[idx] = page[19:1]; mp[idx] = pfn;
      end
   endtask

   task automatic step_lcg();
      lcg = lcg * 32'd1103515245 + 32'd12345;
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_va = '0;
      fill_valid = 1'b0; fill_wr = 1'b0; fill_page = '0; fill_pfn = '0;
      fill_v = 1'b0; fill_d = 1'b0; inval = 1'b0;
      for (int k = 0; k < 4; k++) begin mv[k] = 1'b0; mt[k] = '0; mp[k] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing hits after reset, for every kind and parity
      for (int s = 0; s < 4; s++) probe("reset R1", s[1], {19'h0, s[0], 12'h000});

      // R6 R10 R2: fill each slot alone, probe all four slots with matching and other tags
      for (int s = 0; s < 4; s++) begin
         logic [18:0] tg;
         tg = 19'h12340 + 19'(s * 19'h1111);
         fill(1'b1, s[1], {tg, s[0]}, 20'hA0000 + 20'(s), 1'b1, 1'b1, 1'b0);
         for (int q = 0; q < 4; q++) begin
            probe("slot R6 R10", q[1], {tg, q[0], 12'h5A5});
            probe("slot other tag R2", q[1], {tg ^ 19'h00001, q[0], 12'hFFF});
         end
      end

      // R4: offset sweep on a known hit
      for (int o = 0; o < 4096; o += 273) probe("offset R4", 1'b0, {19'h12340, 1'b0, 12'(o)});

      // R8: flush clears all
      fill(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
      for (int q = 0; q < 4; q++) probe("flush R8", q[1], {19'h12340 + 19'(q * 19'h1111), q[0], 12'h0});

      // R7: refused fills leave slots empty
      fill(1'b1, 1'b1, {19'h0ABCD, 1'b0}, 20'h11111, 1'b1, 1'b0, 1'b0);
      probe("write no D R7", 1'b1, {19'h0ABCD, 1'b0, 12'h010});
      fill(1'b1, 1'b1, {19'h0ABCD, 1'b1}, 20'h22222, 1'b0, 1'b1, 1'b0);
      probe("write no V R7", 1'b1, {19'h0ABCD, 1'b1, 12'h020});
      fill(1'b1, 1'b0, {19'h0ABCD, 1'b0}, 20'h33333, 1'b0, 1'b1, 1'b0);
      probe("read no V R7", 1'b0, {19'h0ABCD, 1'b0, 12'h030});
      fill(1'b1, 1'b0, {19'h0ABCD, 1'b1}, 20'h44444, 1'b1, 1'b0, 1'b0);
      probe("read ignores D R7", 1'b0, {19'h0ABCD, 1'b1, 12'h040});

      // R9: flush and fill in the same cycle
      fill(1'b1, 1'b0, {19'h07777, 1'b0}, 20'h55555, 1'b1, 1'b1, 1'b1);
      probe("flush wins R9", 1'b0, {19'h07777, 1'b0, 12'h050});
      probe("flush wins R9", 1'b0, {19'h0ABCD, 1'b1, 12'h040});

      // mixed sweep over a small tag pool
      for (int n = 0; n < 400; n++) begin
         logic [18:0] tg;
         step_lcg();
         tg = 19'h20000 + 19'(lcg[5:4] * 19'h0101);
         case (lcg[9:8])
            2'd0, 2'd1: fill(1'b1, lcg[10], {tg, lcg[11]}, lcg[31:12], lcg[12] | lcg[13],
                             lcg[14] | lcg[15], lcg[19:16] == 4'h0);
            default:    probe("sweep R3 R6 R7", lcg[10], {tg, lcg[11], lcg[27:16]});
         endcase
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule